// File: doc/BRIEF.md
# Memory Bus Cycle Sequencer

This block is a bus master that turns single read and write requests from a processor-side port into timed cycles on an external memory bus. The external bus has an address bus, a shared bidirectional data bus, an active-low read strobe, an active-low write strobe, and a ready input from the memory. A slow device holds ready low to stretch a cycle.

Every transfer passes through three phases: address, middle and end. With ready high, a transfer takes exactly three clocks on the bus. Each clock in which ready is low during the middle phase adds one wait clock. Ready is sampled only in that phase. A read asserts its strobe together with the address. A write first sets up address and data and asserts its strobe one clock later. Both strobes fall inactive at the close of the end phase, and read data is captured at that same edge. The processor side sees a busy flag for the length of the transfer and then a one-clock done pulse, with the read word held on its read-data output.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After reset, mem_rd_n and mem_wr_n are 1, cpu_done and cpu_busy are 0, and the controller does not drive mem_data.
- R2: In the first clock after a read request is accepted, mem_addr holds the requested address and mem_rd_n is 0. The address stays stable until the transfer completes.
- R3: A read keeps mem_rd_n at 0 from its first clock through its end phase. It captures mem_data at the edge that closes the end phase. That word appears on cpu_rdata while cpu_done is 1, and mem_rd_n is 1 in that same clock.
- R4: In the first clock of a write, mem_addr and mem_data carry the request's address and data while mem_wr_n is still 1. mem_wr_n goes to 0 in the second clock.
- R5: A write keeps mem_wr_n at 0 and the write data on mem_data from its second clock through its end phase. mem_wr_n returns to 1 in the clock where cpu_done is 1.
- R6: With mem_ready high, cpu_done is 1 exactly three clock edges after the edge that accepts the request.
- R7: Each clock of the middle phase with mem_ready low adds one clock to the transfer. The value of mem_ready during the address and end phases has no effect.
- R8: cpu_done is a single-clock pulse. cpu_busy is 1 from acceptance until the done clock. A request raised while busy starts no transfer.
- R9: The controller drives mem_data only during write transfers. The read and write strobes are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Transfer request, sampled while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Request address |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Last read word |
| cpu_done | output | 1 | One-clock completion pulse |
| cpu_busy | output | 1 | Transfer in progress |
| mem_addr | output | AW | Memory address bus |
| mem_data | inout | DW | Memory data bus |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_ready | input | 1 | Memory ready, low inserts wait clocks |

## Verification
The assertions check the phase rules on every cycle:
- The middle phase holds while ready is low and advances when ready is high.
- The end phase always produces done, and done lasts one clock.
- The strobes never overlap, and write strobes never appear in the address phase.
- The data bus is driven only for writes.
- The address stays stable through a transfer.

Only the bench scenarios can show the following:
- The end-to-end clock counts for each wait-state number.
- That ready is ignored outside the middle phase.
- That the right word returns from memory.
- That a request raised while busy is dropped.
- That the bus is released when idle.

// File: rtl/bus_cycle_pkg.sv
package bus_cycle_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_MID  = 2'd2,
    PH_END  = 2'd3
  } phase_t;

  function automatic phase_t next_phase(phase_t cur, logic req, logic rdy);
    phase_t nxt;
    case (cur)
      PH_IDLE: nxt = req ? PH_ADDR : PH_IDLE;
      PH_ADDR: nxt = PH_MID;
      PH_MID:  nxt = rdy ? PH_END : PH_MID;
      default: nxt = PH_IDLE;
    endcase
    return nxt;
  endfunction

  // read strobe covers every busy phase of a read
  function automatic logic rd_active(phase_t cur, logic is_wr);
    return !is_wr && (cur != PH_IDLE);
  endfunction

  // write strobe starts one phase after the address
  function automatic logic wr_active(phase_t cur, logic is_wr);
    return is_wr && (cur == PH_MID || cur == PH_END);
  endfunction

endpackage

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_cycle_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req,
  input  logic   we,
  input  logic   ready,
  output phase_t phase,
  output logic   accept,
  output logic   finish,
  output logic   busy,
  output logic   done,
  output logic   op_write,
  output logic   rd_strobe,
  output logic   wr_strobe,
  output logic   drive_en
);

  phase_t phase_q;
  logic   op_write_q;
  logic   done_q;

  assign accept = (phase_q == PH_IDLE) && req;
  assign finish = (phase_q == PH_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      op_write_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      phase_q <= next_phase(phase_q, req, ready);
      done_q  <= finish;
      if (accept) op_write_q <= we;
    end
  end

  assign phase     = phase_q;
  assign op_write  = op_write_q;
  assign done      = done_q;
  assign busy      = (phase_q != PH_IDLE);
  assign rd_strobe = rd_active(phase_q, op_write_q);
  assign wr_strobe = wr_active(phase_q, op_write_q);
  assign drive_en  = op_write_q && (phase_q != PH_IDLE);

  p_mid_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MID && !ready) |=> (phase_q == PH_MID));
  p_mid_go_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_MID && ready) |=> (phase_q == PH_END));
  p_addr_to_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ADDR) |=> (phase_q == PH_MID));
  p_end_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_END) |=> (done && phase_q != PH_MID && phase_q != PH_END));
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_strobe && wr_strobe));
  p_wr_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ADDR) |-> !wr_strobe);
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req) |=> ($stable(op_write_q) || $past(phase_q) == PH_END));

endmodule

// File: rtl/bus_cycle_dp.sv
module bus_cycle_dp #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic          busy,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic [DW-1:0] bus_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= addr_in;
        wdata_q <= wdata_in;
      end
      if (capture) rdata_q <= bus_in;
    end
  end

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_q));
  p_capture_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(capture && accept));

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bus_cycle_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_done,
  output logic          cpu_busy,
  output logic [AW-1:0] mem_addr,
  inout  wire  [DW-1:0] mem_data,
  output logic          mem_rd_n,
  output logic          mem_wr_n,
  input  logic          mem_ready
);

  phase_t        phase;
  logic          accept, finish, busy, done, op_write;
  logic          rd_strobe, wr_strobe, drive_en;
  logic [DW-1:0] wdata_q;
  logic          capture;

  bus_cycle_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req(cpu_req), .we(cpu_we), .ready(mem_ready),
    .phase(phase), .accept(accept), .finish(finish), .busy(busy), .done(done),
    .op_write(op_write), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .drive_en(drive_en)
  );

  assign capture = finish && !op_write;

  bus_cycle_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture), .busy(busy),
    .addr_in(cpu_addr), .wdata_in(cpu_wdata), .bus_in(mem_data),
    .addr_q(mem_addr), .wdata_q(wdata_q), .rdata_q(cpu_rdata)
  );

  assign mem_data  = drive_en ? wdata_q : {DW{1'bz}};
  assign mem_rd_n  = !rd_strobe;
  assign mem_wr_n  = !wr_strobe;
  assign cpu_done  = done;
  assign cpu_busy  = busy;

  p_drive_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> (op_write && phase != PH_IDLE && mem_rd_n));
  p_read_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_END && !op_write) |=> mem_rd_n);

endmodule

// File: tb/bus_cycle_ctrl_test.sv
module bus_cycle_ctrl_test;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          cpu_done, cpu_busy;
  logic [AW-1:0] mem_addr;
  wire  [DW-1:0] mem_data;
  logic          mem_rd_n, mem_wr_n;
  logic          mem_ready = 1'b1;
  logic          probe_en = 1'b0;
  logic [DW-1:0] probe_val = '0;
  logic [DW-1:0] bmem [0:255];
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bus_cycle_ctrl #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_done(cpu_done), .cpu_busy(cpu_busy), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_ready(mem_ready)
  );

  assign mem_data = !mem_rd_n ? bmem[mem_addr[7:0]] :
                    (probe_en ? probe_val : {DW{1'bz}});

  function automatic logic [DW-1:0] seed_word(int i);
    return DW'((i * 16'h3a7) ^ 16'h5c21);
  endfunction

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic probe_bus(string rq);
    @(negedge clk);
    probe_val = DW'($urandom);
    probe_en  = 1'b1;
    #1;
    chk(mem_data == probe_val, rq, 32'(mem_data), 32'(probe_val));
    probe_en = 1'b0;
  endtask

  // one transfer, w middle-phase wait clocks, optional request poke while busy
  task automatic xfer(bit we, logic [AW-1:0] a, logic [DW-1:0] d, int w, bit poke);
    int low_cnt = 0;
    int done_at = 0;
    logic [DW-1:0] exp_rd = bmem[a[7:0]];
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    mem_ready = 1'b0;
    for (int n = 1; n <= w + 5; n++) begin
      @(negedge clk);
      cpu_req = 1'b0;
      if (poke && n == 2) begin
        cpu_req = 1'b1; cpu_we = ~we; cpu_addr = a ^ 16'h00ff;
      end
      // ready high only in the last middle clock; low in address and end phases (R7)
      mem_ready = (n == w + 2);
      if (n == 1) begin
        chk(mem_addr == a, "R2 addr first clock", 32'(mem_addr), 32'(a));
        if (!we) chk(mem_rd_n == 1'b0, "R2 rd strobe first clock", 32'(mem_rd_n), 0);
        else begin
          chk(mem_wr_n == 1'b1, "R4 wr strobe inactive first clock", 32'(mem_wr_n), 1);
          chk(mem_data == d, "R4 data first clock", 32'(mem_data), 32'(d));
        end
      end
      if (n == 2 && we)
        chk(mem_wr_n == 1'b0, "R4 wr strobe second clock", 32'(mem_wr_n), 0);
      if (n <= w + 3) begin
        chk(cpu_busy == 1'b1, "R8 busy during transfer", 32'(cpu_busy), 1);
        chk(!(mem_rd_n == 1'b0 && mem_wr_n == 1'b0), "R9 strobe overlap", 32'({mem_rd_n, mem_wr_n}), 32'h3);
        if (we && n >= 2) chk(mem_data == d, "R5 data held", 32'(mem_data), 32'(d));
        if (!we ? !mem_rd_n : !mem_wr_n) low_cnt++;
      end
      if (cpu_done && done_at == 0) done_at = n;
      if (n == w + 4) begin
        chk(cpu_done == 1'b1, "R6 R7 done timing", 32'(done_at), 32'(w + 4));
        chk(cpu_busy == 1'b0, "R8 busy low at done", 32'(cpu_busy), 0);
        if (!we) begin
          chk(cpu_rdata == exp_rd, "R3 read data", 32'(cpu_rdata), 32'(exp_rd));
          chk(mem_rd_n == 1'b1, "R3 rd strobe off at done", 32'(mem_rd_n), 1);
          chk(low_cnt == w + 3, "R3 rd strobe length", 32'(low_cnt), 32'(w + 3));
        end else begin
          chk(mem_wr_n == 1'b1, "R5 wr strobe off at done", 32'(mem_wr_n), 1);
          chk(low_cnt == w + 2, "R5 wr strobe length", 32'(low_cnt), 32'(w + 2));
        end
      end
      if (n == w + 5) begin
        chk(cpu_done == 1'b0, "R8 done single pulse", 32'(cpu_done), 0);
        chk(mem_rd_n && mem_wr_n && !cpu_busy, "R8 no transfer from busy request",
            32'({mem_rd_n, mem_wr_n, cpu_busy}), 32'h6);
        chk(mem_addr == a, "R8 address unchanged", 32'(mem_addr), 32'(a));
      end
    end
    if (we) bmem[a[7:0]] = d;
    mem_ready = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = seed_word(i);
    void'($urandom(32'd20250));
    repeat (3) @(negedge clk);
    chk(mem_rd_n && mem_wr_n, "R1 strobes in reset", 32'({mem_rd_n, mem_wr_n}), 32'h3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cpu_done && !cpu_busy, "R1 done busy after reset", 32'({cpu_done, cpu_busy}), 0);
    chk(mem_rd_n && mem_wr_n, "R1 strobes after reset", 32'({mem_rd_n, mem_wr_n}), 32'h3);
    probe_bus("R1 bus released after reset");
    // directed corners
    xfer(1'b0, 16'h0010, '0, 0, 1'b0);
    xfer(1'b1, 16'h0020, 16'hbeef, 0, 1'b0);
    probe_bus("R9 bus released after write");
    xfer(1'b0, 16'h0020, '0, 3, 1'b0);
    xfer(1'b1, 16'h0031, 16'h1234, 1, 1'b1);
    xfer(1'b0, 16'h0045, '0, 2, 1'b1);
    // random mix
    for (int t = 0; t < 40; t++) begin
      bit we = 1'($urandom);
      xfer(we, AW'($urandom), DW'($urandom), int'($urandom % 5), 1'($urandom));
      if ((t % 8) == 0) probe_bus("R9 bus released when idle");
    end
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule